// File: doc/BRIEF.md
# Two-Axis Encoder Counter Host Register Interface

This block is the host-facing side of a two-axis incremental-encoder counter. A processor reaches it through an asynchronous strobe bus. That bus carries an active-low chip select, active-low read and write strobes, a 3-bit register select, an axis select and a 16-bit data path. A static strap input picks the bus mapping. In the narrow mapping every 32-bit register is reached one byte at a time. In the wide mapping it is reached one 16-bit half at a time, using only the even selects. Each axis keeps two 8-bit mode registers and a 32-bit preset register, and these drive the counter core. It also keeps a 32-bit snapshot register and a status byte, which the host can read back.

All bus inputs are first moved into the system-clock domain through a synchroniser chain. A write is committed at its trailing edge. Writing the command location does not store anything. Instead it triggers actions on the selected axis only: one-cycle counter-clear and counter-load pulses, a snapshot copy of the live count, a clear of the sticky status bits, a master clear, and sign set and clear. The tri-state pads are represented by a data-out bus and an output-enable.

Top module: `qenc_host_regs`

## Requirements
- R1: While `rst` is high, and after it falls, every mode register, preset, snapshot and status bit is zero, `dout_en` is low and both pulse outputs are low.
- R2: Byte mapping (`wide_mode`=0) writes: select 0 writes mode register A, 1 writes mode register B, and 2, 3, 4, 5 write preset bits [7:0], [15:8], [23:16], [31:24] from `din[7:0]`; 6 is the command location; a write to select 7 changes nothing.
- R3: Word mapping (`wide_mode`=1) writes: select 0 writes mode A from `din[7:0]` and mode B from `din[15:8]`; 2 writes preset [15:0]; 4 writes preset [31:16]; 6 is the command location; odd selects change nothing.
- R4: Byte mapping reads put on `dout[7:0]` (upper byte zero): select 0 mode A, 1 mode B, 2 to 5 snapshot bytes 0 to 3, 6 the status byte, 7 zero.
- R5: Word mapping reads: select 0 gives {mode B, mode A}, 2 snapshot [15:0], 4 snapshot [31:16], 6 {8'h00, status}; odd selects give zero.
- R6: With `cs_n` high no read drives the bus (`dout_en` low, `dout` zero) and a write strobe changes nothing.
- R7: A write takes effect only after `wr_n` returns high, and it stores the select, axis and data present in the last sampled cycle that the strobe was low.
- R8: `axis_sel` low addresses axis 0 and high addresses axis 1. The other axis is untouched.
- R9: Command bit 0 gives exactly one cycle of `cnt_clr_p` and bit 1 one cycle of `cnt_load_p`, on the selected axis only. Bit 7 has no effect.
- R10: Command bit 2 copies that axis's `cnt_value` into its snapshot register.
- R11: The status byte is {carry, borrow, compare, index, count-enabled, 0, up, sign} from bit 7 down to bit 0. The four upper bits are sticky and are set by `cnt_evt[3:0]` (bit 3 carry to bit 0 index). Count-enabled and up follow `cnt_en` and `cnt_up` live. Command bit 3 clears only the four sticky bits.
- R12: Command bit 4 clears both mode registers, the preset, the snapshot and the whole status, sign included, for that axis.
- R13: Command bit 5 sets the sign bit and bit 6 clears it. Bit 6 wins when both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, committed at rising edge |
| reg_sel | input | 3 | Register select |
| axis_sel | input | 1 | Axis select |
| wide_mode | input | 1 | Strap: 1 word mapping, 0 byte mapping |
| din | input | 16 | Write data from host |
| dout | output | 16 | Read data to pads |
| dout_en | output | 1 | Pad output enable |
| cnt_value | input | 2x32 | Live count of each axis |
| cnt_evt | input | 2x4 | Per-axis event pulses: carry, borrow, compare, index |
| cnt_en | input | 2 | Live count-enabled state per axis |
| cnt_up | input | 2 | Live count direction per axis |
| mode_a | output | 2x8 | Mode register A per axis |
| mode_b | output | 2x8 | Mode register B per axis |
| preset | output | 2x32 | Preset register per axis |
| cnt_clr_p | output | 2 | One-cycle counter clear pulse per axis |
| cnt_load_p | output | 2 | One-cycle counter load pulse per axis |

## Verification
The assertions watch several properties on every cycle. Command pulses last a single cycle and never appear on both axes together. Sticky status bits never drop without a clear command. A master clear empties the registers on the next cycle. A snapshot holds the count seen at the command. Mode registers stay still unless a write was committed. The bench scenarios are needed for the rest: the select decoding in both mappings, the trailing-edge commit with data changed mid-strobe, the ignored selects and the deselected strobe, and the live status bits. Each of these is observed through the bus and the register outputs against a reference model.

// File: rtl/qenc_host_pkg.sv
package qenc_host_pkg;

    parameter int REG_W   = 32;
    parameter int BYTE_W  = 8;
    parameter int BUS_W   = 16;
    parameter int SEL_W   = 3;
    parameter int AXIS_W  = 1;
    parameter int EVT_W   = 4;
    localparam int NUM_AXES = 1 << AXIS_W;

    // command byte bit positions
    localparam int CMD_CNT_CLR  = 0;
    localparam int CMD_CNT_LOAD = 1;
    localparam int CMD_SNAP     = 2;
    localparam int CMD_STS_CLR  = 3;
    localparam int CMD_MASTER   = 4;
    localparam int CMD_SIGN_SET = 5;
    localparam int CMD_SIGN_CLR = 6;

    typedef struct packed {
        logic              cs;
        logic              rd;
        logic              wr;
        logic              wide;
        logic [SEL_W-1:0]  sel;
        logic [AXIS_W-1:0] axis;
        logic [BUS_W-1:0]  data;
    } bus_t;

    typedef struct packed {
        logic              cs;
        logic              rd;
        logic              wide;
        logic [SEL_W-1:0]  sel;
        logic [AXIS_W-1:0] axis;
    } rd_view_t;

    typedef struct packed {
        logic              commit;
        logic              wide;
        logic [SEL_W-1:0]  sel;
        logic [AXIS_W-1:0] axis;
        logic [BUS_W-1:0]  data;
    } wr_req_t;

    typedef enum logic [3:0] {
        W_NONE, W_MODE_A, W_MODE_B, W_MODE_AB,
        W_PRE_B0, W_PRE_B1, W_PRE_B2, W_PRE_B3,
        W_PRE_W0, W_PRE_W1, W_CMD
    } wtgt_e;

    typedef enum logic [3:0] {
        R_NONE, R_MODE_A, R_MODE_B, R_MODE_AB,
        R_SNP_B0, R_SNP_B1, R_SNP_B2, R_SNP_B3,
        R_SNP_W0, R_SNP_W1, R_STATUS
    } rtgt_e;

    function automatic wtgt_e decode_write(input logic wide, input logic [SEL_W-1:0] sel);
        wtgt_e t;
        t = W_NONE;
        if (wide) begin
            case (sel)
                3'd0: t = W_MODE_AB;
                3'd2: t = W_PRE_W0;
                3'd4: t = W_PRE_W1;
                3'd6: t = W_CMD;
                default: t = W_NONE;
            endcase
        end else begin
            case (sel)
                3'd0: t = W_MODE_A;
                3'd1: t = W_MODE_B;
                3'd2: t = W_PRE_B0;
                3'd3: t = W_PRE_B1;
                3'd4: t = W_PRE_B2;
                3'd5: t = W_PRE_B3;
                3'd6: t = W_CMD;
                default: t = W_NONE;
            endcase
        end
        return t;
    endfunction

    function automatic rtgt_e decode_read(input logic wide, input logic [SEL_W-1:0] sel);
        rtgt_e t;
        t = R_NONE;
        if (wide) begin
            case (sel)
                3'd0: t = R_MODE_AB;
                3'd2: t = R_SNP_W0;
                3'd4: t = R_SNP_W1;
                3'd6: t = R_STATUS;
                default: t = R_NONE;
            endcase
        end else begin
            case (sel)
                3'd0: t = R_MODE_A;
                3'd1: t = R_MODE_B;
                3'd2: t = R_SNP_B0;
                3'd3: t = R_SNP_B1;
                3'd4: t = R_SNP_B2;
                3'd5: t = R_SNP_B3;
                3'd6: t = R_STATUS;
                default: t = R_NONE;
            endcase
        end
        return t;
    endfunction

endpackage

// File: rtl/qenc_bus_sync.sv
module qenc_bus_sync
    import qenc_host_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_t     bus_raw,
    output rd_view_t rview,
    output wr_req_t  wreq
);

    bus_t pipe [STAGES];

    // stage after the synchroniser: the bus as seen one cycle earlier
    logic              d_cs;
    logic              d_wr;
    logic              d_wide;
    logic [SEL_W-1:0]  d_sel;
    logic [AXIS_W-1:0] d_axis;
    logic [BUS_W-1:0]  d_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= bus_raw;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_cs   <= 1'b0;
            d_wr   <= 1'b0;
            d_wide <= 1'b0;
            d_sel  <= '0;
            d_axis <= '0;
            d_data <= '0;
        end else begin
            d_cs   <= pipe[STAGES-1].cs;
            d_wr   <= pipe[STAGES-1].wr;
            d_wide <= pipe[STAGES-1].wide;
            d_sel  <= pipe[STAGES-1].sel;
            d_axis <= pipe[STAGES-1].axis;
            d_data <= pipe[STAGES-1].data;
        end
    end

    always_comb begin
        rview.cs   = pipe[STAGES-1].cs;
        rview.rd   = pipe[STAGES-1].rd;
        rview.wide = pipe[STAGES-1].wide;
        rview.sel  = pipe[STAGES-1].sel;
        rview.axis = pipe[STAGES-1].axis;

        // trailing edge of the write strobe while selected
        wreq.commit = d_wr & ~pipe[STAGES-1].wr & d_cs;
        wreq.wide   = d_wide;
        wreq.sel    = d_sel;
        wreq.axis   = d_axis;
        wreq.data   = d_data;
    end

endmodule

// File: rtl/qenc_axis_regs.sv
module qenc_axis_regs
    import qenc_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  wtgt_e              tgt,
    input  logic [BUS_W-1:0]   wdata,
    input  logic [REG_W-1:0]   cnt_value,
    input  logic [EVT_W-1:0]   evt,
    input  logic               cen,
    input  logic               up,
    output logic [BYTE_W-1:0]  mode_a,
    output logic [BYTE_W-1:0]  mode_b,
    output logic [REG_W-1:0]   preset,
    output logic [REG_W-1:0]   snapshot,
    output logic [BYTE_W-1:0]  status,
    output logic               clr_p,
    output logic               load_p
);

    logic [EVT_W-1:0] sticky;
    logic             sign;
    logic             cmd_v;
    logic             master;
    logic             sts_clr;
    logic             snap;

    always_comb begin
        cmd_v   = wr_en && (tgt == W_CMD);
        master  = cmd_v & wdata[CMD_MASTER];
        sts_clr = cmd_v & wdata[CMD_STS_CLR];
        snap    = cmd_v & wdata[CMD_SNAP] & ~master;
        status  = {sticky, cen, 1'b0, up, sign};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_a   <= '0;
            mode_b   <= '0;
            preset   <= '0;
            snapshot <= '0;
            sticky   <= '0;
            sign     <= 1'b0;
            clr_p    <= 1'b0;
            load_p   <= 1'b0;
        end else begin
            clr_p  <= cmd_v & wdata[CMD_CNT_CLR];
            load_p <= cmd_v & wdata[CMD_CNT_LOAD];
            if (master) begin
                mode_a   <= '0;
                mode_b   <= '0;
                preset   <= '0;
                snapshot <= '0;
                sticky   <= evt;
                sign     <= 1'b0;
            end else begin
                if (wr_en) begin
                    case (tgt)
                        W_MODE_A:  mode_a <= wdata[BYTE_W-1:0];
                        W_MODE_B:  mode_b <= wdata[BYTE_W-1:0];
                        W_MODE_AB: begin
                            mode_a <= wdata[BYTE_W-1:0];
                            mode_b <= wdata[BUS_W-1:BYTE_W];
                        end
                        W_PRE_B0:  preset[7:0]   <= wdata[BYTE_W-1:0];
                        W_PRE_B1:  preset[15:8]  <= wdata[BYTE_W-1:0];
                        W_PRE_B2:  preset[23:16] <= wdata[BYTE_W-1:0];
                        W_PRE_B3:  preset[31:24] <= wdata[BYTE_W-1:0];
                        W_PRE_W0:  preset[15:0]  <= wdata;
                        W_PRE_W1:  preset[31:16] <= wdata;
                        default: ;
                    endcase
                end
                if (snap) snapshot <= cnt_value;
                sticky <= (sts_clr ? '0 : sticky) | evt;
                if (cmd_v & wdata[CMD_SIGN_CLR])      sign <= 1'b0;
                else if (cmd_v & wdata[CMD_SIGN_SET]) sign <= 1'b1;
            end
        end
    end

    // R9: counter pulses never last longer than one cycle
    a_r9_clr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        clr_p |=> !clr_p);
    a_r9_load_one_cycle: assert property (@(posedge clk) disable iff (rst)
        load_p |=> !load_p);
    // R11: sticky bits only fall on a clear command or master clear
    a_r11_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (!sts_clr && !master) |=> ((sticky & $past(sticky)) == $past(sticky)));
    // R12: master clear empties the axis on the next cycle
    a_r12_master_clears: assert property (@(posedge clk) disable iff (rst)
        master |=> (mode_a == '0 && mode_b == '0 && preset == '0 && snapshot == '0 && !sign));
    // R10: snapshot holds the count seen at the command
    a_r10_snap_copy: assert property (@(posedge clk) disable iff (rst)
        snap |=> (snapshot == $past(cnt_value)));

endmodule

// File: rtl/qenc_read_mux.sv
module qenc_read_mux
    import qenc_host_pkg::*;
(
    input  rtgt_e                              tgt,
    input  logic [AXIS_W-1:0]                  axis,
    input  logic [NUM_AXES-1:0][BYTE_W-1:0]    mode_a,
    input  logic [NUM_AXES-1:0][BYTE_W-1:0]    mode_b,
    input  logic [NUM_AXES-1:0][REG_W-1:0]     snapshot,
    input  logic [NUM_AXES-1:0][BYTE_W-1:0]    status,
    output logic [BUS_W-1:0]                   rdata
);

    logic [BYTE_W-1:0] ma;
    logic [BYTE_W-1:0] mb;
    logic [REG_W-1:0]  sn;
    logic [BYTE_W-1:0] st;

    always_comb begin
        ma = mode_a[axis];
        mb = mode_b[axis];
        sn = snapshot[axis];
        st = status[axis];
        case (tgt)
            R_MODE_A:  rdata = {{BYTE_W{1'b0}}, ma};
            R_MODE_B:  rdata = {{BYTE_W{1'b0}}, mb};
            R_MODE_AB: rdata = {mb, ma};
            R_SNP_B0:  rdata = {{BYTE_W{1'b0}}, sn[7:0]};
            R_SNP_B1:  rdata = {{BYTE_W{1'b0}}, sn[15:8]};
            R_SNP_B2:  rdata = {{BYTE_W{1'b0}}, sn[23:16]};
            R_SNP_B3:  rdata = {{BYTE_W{1'b0}}, sn[31:24]};
            R_SNP_W0:  rdata = sn[15:0];
            R_SNP_W1:  rdata = sn[31:16];
            R_STATUS:  rdata = {{BYTE_W{1'b0}}, st};
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/qenc_host_regs.sv
module qenc_host_regs
    import qenc_host_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cs_n,
    input  logic                              rd_n,
    input  logic                              wr_n,
    input  logic [SEL_W-1:0]                  reg_sel,
    input  logic [AXIS_W-1:0]                 axis_sel,
    input  logic                              wide_mode,
    input  logic [BUS_W-1:0]                  din,
    output logic [BUS_W-1:0]                  dout,
    output logic                              dout_en,
    input  logic [NUM_AXES-1:0][REG_W-1:0]    cnt_value,
    input  logic [NUM_AXES-1:0][EVT_W-1:0]    cnt_evt,
    input  logic [NUM_AXES-1:0]               cnt_en,
    input  logic [NUM_AXES-1:0]               cnt_up,
    output logic [NUM_AXES-1:0][BYTE_W-1:0]   mode_a,
    output logic [NUM_AXES-1:0][BYTE_W-1:0]   mode_b,
    output logic [NUM_AXES-1:0][REG_W-1:0]    preset,
    output logic [NUM_AXES-1:0]               cnt_clr_p,
    output logic [NUM_AXES-1:0]               cnt_load_p
);

    bus_t      bus_raw;
    rd_view_t  rview;
    wr_req_t   wreq;
    wtgt_e     wtgt;
    rtgt_e     rtgt;
    logic [BUS_W-1:0]                 rdata;
    logic [NUM_AXES-1:0][REG_W-1:0]   snapshot;
    logic [NUM_AXES-1:0][BYTE_W-1:0]  status;

    always_comb begin
        bus_raw.cs   = ~cs_n;
        bus_raw.rd   = ~rd_n;
        bus_raw.wr   = ~wr_n;
        bus_raw.wide = wide_mode;
        bus_raw.sel  = reg_sel;
        bus_raw.axis = axis_sel;
        bus_raw.data = din;
    end

    qenc_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .bus_raw (bus_raw),
        .rview   (rview),
        .wreq    (wreq)
    );

    assign wtgt = decode_write(wreq.wide, wreq.sel);
    assign rtgt = decode_read(rview.wide, rview.sel);

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
        qenc_axis_regs i_axis (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wreq.commit && (wreq.axis == AXIS_W'(g))),
            .tgt       (wtgt),
            .wdata     (wreq.data),
            .cnt_value (cnt_value[g]),
            .evt       (cnt_evt[g]),
            .cen       (cnt_en[g]),
            .up        (cnt_up[g]),
            .mode_a    (mode_a[g]),
            .mode_b    (mode_b[g]),
            .preset    (preset[g]),
            .snapshot  (snapshot[g]),
            .status    (status[g]),
            .clr_p     (cnt_clr_p[g]),
            .load_p    (cnt_load_p[g])
        );
    end

    qenc_read_mux i_rmux (
        .tgt      (rtgt),
        .axis     (rview.axis),
        .mode_a   (mode_a),
        .mode_b   (mode_b),
        .snapshot (snapshot),
        .status   (status),
        .rdata    (rdata)
    );

    always_comb begin
        dout_en = rview.cs & rview.rd;
        dout    = dout_en ? rdata : '0;
    end

    // R8/R9: a command pulse reaches one axis at a time
    a_r9_load_one_axis: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt_load_p));
    a_r9_clr_one_axis: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt_clr_p));
    // R7: mode registers move only after a committed write
    a_r7_mode_still: assert property (@(posedge clk) disable iff (rst)
        !$past(wreq.commit) |-> ($stable(mode_a) && $stable(mode_b) && $stable(preset)));

endmodule

// File: tb/test_qenc_host_regs.sv
module test_qenc_host_regs;
    import qenc_host_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [SEL_W-1:0] reg_sel = '0;
    logic [AXIS_W-1:0] axis_sel = '0;
    logic wide_mode = 1'b0;
    logic [BUS_W-1:0] din = '0;
    logic [BUS_W-1:0] dout;
    logic dout_en;
    logic [NUM_AXES-1:0][REG_W-1:0] cnt_value = '0;
    logic [NUM_AXES-1:0][EVT_W-1:0] cnt_evt = '0;
    logic [NUM_AXES-1:0] cnt_en = '0, cnt_up = '0;
    logic [NUM_AXES-1:0][BYTE_W-1:0] mode_a, mode_b;
    logic [NUM_AXES-1:0][REG_W-1:0] preset;
    logic [NUM_AXES-1:0] cnt_clr_p, cnt_load_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    qenc_host_regs i_qenc_host_regs (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .reg_sel(reg_sel), .axis_sel(axis_sel), .wide_mode(wide_mode),
        .din(din), .dout(dout), .dout_en(dout_en),
        .cnt_value(cnt_value), .cnt_evt(cnt_evt), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .mode_a(mode_a), .mode_b(mode_b), .preset(preset),
        .cnt_clr_p(cnt_clr_p), .cnt_load_p(cnt_load_p)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [7:0]  m_ma [NUM_AXES];
    logic [7:0]  m_mb [NUM_AXES];
    logic [31:0] m_pre [NUM_AXES];
    logic [31:0] m_snp [NUM_AXES];
    logic [3:0]  m_stk [NUM_AXES];
    logic        m_sgn [NUM_AXES];
    int n_clr [NUM_AXES];
    int n_load [NUM_AXES];

    always @(negedge clk) begin
        for (int a = 0; a < NUM_AXES; a++) begin
            if (cnt_clr_p[a])  n_clr[a]++;
            if (cnt_load_p[a]) n_load[a]++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_status(input int ax);
        return {m_stk[ax], cnt_en[ax], 1'b0, cnt_up[ax], m_sgn[ax]};
    endfunction

    function automatic logic [15:0] exp_read(input bit wide, input int ax, input int sel);
        if (wide) begin
            case (sel)
                0: return {m_mb[ax], m_ma[ax]};
                2: return m_snp[ax][15:0];
                4: return m_snp[ax][31:16];
                6: return {8'h00, m_status(ax)};
                default: return 16'h0;
            endcase
        end
        case (sel)
            0: return {8'h00, m_ma[ax]};
            1: return {8'h00, m_mb[ax]};
            2: return {8'h00, m_snp[ax][7:0]};
            3: return {8'h00, m_snp[ax][15:8]};
            4: return {8'h00, m_snp[ax][23:16]};
            5: return {8'h00, m_snp[ax][31:24]};
            6: return {8'h00, m_status(ax)};
            default: return 16'h0;
        endcase
    endfunction

    task automatic model_write(input bit wide, input int ax, input int sel, input logic [15:0] d);
        bit cmd;
        cmd = (sel == 6);
        if (wide) begin
            case (sel)
                0: begin m_ma[ax] = d[7:0]; m_mb[ax] = d[15:8]; end
                2: m_pre[ax][15:0] = d;
                4: m_pre[ax][31:16] = d;
                default: ;
            endcase
        end else begin
            case (sel)
                0: m_ma[ax] = d[7:0];
                1: m_mb[ax] = d[7:0];
                2: m_pre[ax][7:0] = d[7:0];
                3: m_pre[ax][15:8] = d[7:0];
                4: m_pre[ax][23:16] = d[7:0];
                5: m_pre[ax][31:24] = d[7:0];
                default: ;
            endcase
        end
        if (cmd) begin
            if (d[4]) begin
                m_ma[ax] = 0; m_mb[ax] = 0; m_pre[ax] = 0; m_snp[ax] = 0;
                m_stk[ax] = 0; m_sgn[ax] = 0;
            end else begin
                if (d[2]) m_snp[ax] = cnt_value[ax];
                if (d[3]) m_stk[ax] = 0;
                if (d[6]) m_sgn[ax] = 0;
                else if (d[5]) m_sgn[ax] = 1;
            end
        end
    endtask

    task automatic check_regs(input string tag);
        for (int a = 0; a < NUM_AXES; a++) begin
            check(tag, {24'h0, mode_a[a]}, {24'h0, m_ma[a]});
            check(tag, {24'h0, mode_b[a]}, {24'h0, m_mb[a]});
            check(tag, preset[a], m_pre[a]);
        end
    endtask

    task automatic bus_write(input bit wide, input int ax, input int sel, input logic [15:0] d,
                             input bit sel_chip = 1);
        @(negedge clk);
        for (int a = 0; a < NUM_AXES; a++) begin n_clr[a] = 0; n_load[a] = 0; end
        wide_mode = wide; cs_n = ~sel_chip; reg_sel = sel[2:0]; axis_sel = ax[0]; din = d;
        @(negedge clk); wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        if (sel_chip) model_write(wide, ax, sel, d);
    endtask

    task automatic check_pulses(input string tag, input int ax, input logic [15:0] d, input bit was_cmd);
        for (int a = 0; a < NUM_AXES; a++) begin
            check(tag, n_clr[a],  (was_cmd && a == ax && d[0]) ? 1 : 0);
            check(tag, n_load[a], (was_cmd && a == ax && d[1]) ? 1 : 0);
        end
    endtask

    task automatic bus_read(input string tag, input bit wide, input int ax, input int sel,
                            input bit sel_chip = 1);
        @(negedge clk);
        wide_mode = wide; cs_n = ~sel_chip; rd_n = 1'b0; reg_sel = sel[2:0]; axis_sel = ax[0];
        repeat (4) @(negedge clk);
        check(tag, {31'h0, dout_en}, {31'h0, sel_chip});
        check(tag, {16'h0, dout}, sel_chip ? {16'h0, exp_read(wide, ax, sel)} : 32'h0);
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic inject(input int ax, input logic [3:0] mask);
        @(negedge clk); cnt_evt[ax] = mask;
        @(negedge clk); cnt_evt[ax] = '0;
        m_stk[ax] = m_stk[ax] | mask;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int ax, sel, op;
        bit wide;
        void'($urandom(32'd4242));
        for (int a = 0; a < NUM_AXES; a++) begin
            m_ma[a] = 0; m_mb[a] = 0; m_pre[a] = 0; m_snp[a] = 0; m_stk[a] = 0; m_sgn[a] = 0;
            n_clr[a] = 0; n_load[a] = 0;
        end
        repeat (5) @(negedge clk);
        // R1: outputs during reset
        check("R1 en in reset", {31'h0, dout_en}, 0);
        check("R1 pulses in reset", {30'h0, cnt_clr_p, cnt_load_p}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_regs("R1 regs after reset");
        bus_read("R1 status after reset", 0, 0, 6);
        bus_read("R1 snapshot after reset", 1, 1, 2);

        // R2: byte mapping writes, axis 0 (R8 keeps axis 1 clear)
        bus_write(0, 0, 0, 16'hFF5A);
        bus_write(0, 0, 1, 16'h00C3);
        for (int s = 2; s < 6; s++) bus_write(0, 0, s, 16'h0011 * (s + 1));
        check_regs("R2 byte writes");
        bus_write(0, 0, 7, 16'h00EE);
        check_regs("R2 select 7 ignored");
        bus_read("R4 mode A byte", 0, 0, 0);
        bus_read("R4 mode B byte", 0, 0, 1);
        bus_read("R4 select 7 zero", 0, 0, 7);

        // R3: word mapping writes, axis 1
        bus_write(1, 1, 0, 16'hA55A);
        bus_write(1, 1, 2, 16'h1234);
        bus_write(1, 1, 4, 16'hCAFE);
        check_regs("R3 R8 word writes axis 1");
        for (int s = 1; s < 8; s += 2) bus_write(1, 1, s, 16'hBEEF);
        check_regs("R3 odd selects ignored");
        bus_read("R5 mode pair word", 1, 1, 0);
        bus_read("R5 odd select zero", 1, 1, 3);

        // R6: deselected write and read
        bus_write(0, 0, 0, 16'h0077, 0);
        check_regs("R6 write ignored while deselected");
        bus_read("R6 no drive while deselected", 0, 0, 0, 0);

        // R7: data changes mid-strobe, register holds until release
        @(negedge clk);
        wide_mode = 0; cs_n = 0; reg_sel = 3'd1; axis_sel = 0; din = 16'h0044;
        @(negedge clk); wr_n = 0;
        repeat (5) @(negedge clk);
        check("R7 unchanged while strobe low", {24'h0, mode_b[0]}, {24'h0, m_mb[0]});
        din = 16'h0099;
        repeat (4) @(negedge clk);
        wr_n = 1;
        repeat (2) @(negedge clk); cs_n = 1;
        repeat (4) @(negedge clk);
        m_mb[0] = 8'h99;
        check("R7 last data stored at release", {24'h0, mode_b[0]}, 32'h99);

        // R9: pulses, selected axis only; bit 7 only does nothing
        bus_write(0, 1, 6, 16'h0001); check_pulses("R9 clear pulse axis 1", 1, 16'h0001, 1);
        bus_write(1, 0, 6, 16'h0002); check_pulses("R9 load pulse axis 0", 0, 16'h0002, 1);
        bus_write(0, 0, 6, 16'h0080); check_pulses("R9 bit 7 no pulse", 0, 16'h0080, 1);
        check_regs("R9 bit 7 no register change");
        bus_read("R9 bit 7 status unchanged", 0, 0, 6);

        // R10: snapshot
        cnt_value[0] = 32'hDEADBEEF; cnt_value[1] = 32'h01020304;
        bus_write(0, 0, 6, 16'h0004);
        for (int s = 2; s < 6; s++) bus_read("R10 snapshot byte", 0, 0, s);
        bus_read("R10 other axis snapshot", 1, 1, 4);

        // R11: sticky and live status bits
        cnt_en[1] = 1; cnt_up[1] = 1;
        inject(1, 4'b1010);
        bus_read("R11 sticky and live", 0, 1, 6);
        inject(1, 4'b0101);
        bus_write(0, 1, 6, 16'h0020);
        bus_read("R13 sign set", 1, 1, 6);
        bus_write(0, 1, 6, 16'h0008);
        bus_read("R11 clear keeps live and sign", 0, 1, 6);
        cnt_en[1] = 0;
        bus_read("R11 live enable follows", 0, 1, 6);

        // R13: clear wins over set
        bus_write(0, 1, 6, 16'h0060);
        bus_read("R13 clear wins", 0, 1, 6);

        // R12: master clear on axis 0
        inject(0, 4'b1111);
        bus_write(1, 0, 6, 16'h0030);
        bus_write(1, 0, 6, 16'h0010);
        check_regs("R12 master clear");
        bus_read("R12 status cleared", 1, 0, 6);
        bus_read("R12 snapshot cleared", 1, 0, 4);

        // random mix against the model
        for (int i = 0; i < 120; i++) begin
            op = $urandom % 4; ax = $urandom % NUM_AXES; sel = $urandom % 8;
            wide = $urandom % 2; d = 16'($urandom);
            cnt_value[ax] = $urandom; cnt_en = 2'($urandom); cnt_up = 2'($urandom);
            case (op)
                0, 1: begin
                    if (($urandom % 3) == 0) sel = 6;
                    bus_write(wide, ax, sel, d);
                    check_regs("R2 R3 R8 random write");
                    check_pulses("R9 random command", ax, d, sel == 6 && !(wide && sel[0]));
                end
                2: bus_read(wide ? "R5 random read" : "R4 random read", wide, ax, sel);
                default: inject(ax, 4'($urandom));
            endcase
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule